// File: doc/BRIEF.md
# Shared-Function GPIO Port Controller

An eight-bit bidirectional port for a microcontroller-class chip. A CPU register bus writes an output latch, a direction register, a pull-up register and an interrupt control/status register, and reads the port back. Each pin appears as three signals: a sampled input, an output value and an output enable. The pad itself lives outside the block.

Several bits are shared with neighbours. Bits 7 and 6 are open-drain outputs and also serve as falling-edge interrupt sources, with a pull-up request for each. Bit 5 can be taken over by a timer event output. Bits 4 and 3 feed the timer's event input and its input-capture input. For every bit, the direction bit also chooses what a read returns: the latch when the bit is 1, the synchronized pin when it is 0. The interrupt logic watches that same value. A latch write can therefore raise an interrupt flag on a pin that is set as an output.

Each interrupt channel runs a two-state edge tracker. State `SRC_LOW` moves to `SRC_HIGH` when the source reads 1. State `SRC_HIGH` moves back to `SRC_LOW` when the source reads 0, and that move is the only one that reports a falling edge. Both trackers reset into `SRC_LOW`.

Top module: `shared_gpio_port`

## Requirements
- R1: After reset, every register reads 0, `pin_oe` is 0, `pull_up_en` is 0 and `irq_req` is 0.
- R2: A read at address 0 returns, for each bit, the latch when that direction bit is 1 and the synchronized pin level when it is 0. This holds for all eight bits, bit 5 included, whatever the event-output mode.
- R3: Bits 7 and 6 drive `pin_out` 0 and are enabled only when the direction bit is 1 and the latch bit is 0. Register address 2 holds the pull-up requests in bit positions 7 and 6, shown on `pull_up_en[0]` and `pull_up_en[1]`. The other bits of address 2 read 0.
- R4: Bits 4 to 0, and bit 5 while `evo_en` is 0, are push-pull: `pin_oe` equals the direction bit and `pin_out` equals the latch bit.
- R5: While `evo_en` is 1, bit 5 has `pin_oe` 1 and `pin_out` equal to `evo_val`, whatever its direction bit holds.
- R6: `tmr_event_o` and `tmr_capture_o` follow the synchronized levels of pins 4 and 3, whatever the direction and latch of those bits. This includes edges caused by the port's own output.
- R7: Channel 0 watches bit 7 and channel 1 watches bit 6, each through its R2 read value. A 1-to-0 change of that value sets the channel's flag, which is bit 4 (channel 0) or bit 5 (channel 1) of address 3. The change may come from the pin or from a latch write.
- R8: Writing 1 to a flag bit at address 3 clears it. Writing 0 leaves it unchanged. If a set and a clear arrive in the same cycle, the set wins.
- R9: `irq_req[n]` equals flag n ANDed with enable n, where the enables are bits 0 and 1 of address 3.
- R10: A pin change reaches the read data two clock edges after it is applied, not one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 latch, 1 direction, 2 pull-up, 3 interrupt control/status |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 8 | Raw pin levels |
| pin_out | output | 8 | Output value per pin |
| pin_oe | output | 8 | Output enable per pin |
| pull_up_en | output | 2 | Pull-up requests for bits 7 and 6 |
| evo_en | input | 1 | Timer event output owns bit 5 |
| evo_val | input | 1 | Timer event output level |
| tmr_event_o | output | 1 | Synchronized pin 4 to the timer event input |
| tmr_capture_o | output | 1 | Synchronized pin 3 to the timer capture input |
| irq_req | output | 2 | Interrupt requests, channel 0 and channel 1 |

## Verification
The bench forces a falling edge on bit 6 purely by latch writes. A design that fed the interrupt tracker from the raw pin would miss that flag. It then lines up a flag set with a write-1 clear in the same cycle. A design that let the clear win would drop the event and read 0. Bit 5 is put under event-output control with its direction bit at 0, to catch a design that still lets the direction bit gate the output. Bits 4 and 3 are driven as outputs to show that the timer signals keep following the pins, as opposed to being masked. The single-edge probe of the read path exposes a synchronizer that is one stage short.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int PORT_W   = 8;
    localparam int IRQ_CH   = 2;
    localparam int EN_LSB   = 0;
    localparam int FLAG_LSB = 4;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_PULL = 2'd2,
        REG_CTL  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        SRC_LOW  = 1'b0,
        SRC_HIGH = 1'b1
    } edge_st_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_fall_fsm.sv
module gpio_fall_fsm
    import gpio_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    output logic fall
);
    edge_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SRC_LOW;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        fall = 1'b0;
        unique case (st_q)
            SRC_LOW: begin
                if (src) st_d = SRC_HIGH;
            end
            SRC_HIGH: begin
                if (!src) begin
                    st_d = SRC_LOW;
                    fall = 1'b1;
                end
            end
            default: st_d = SRC_LOW;
        endcase
    end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int           W       = 8,
    parameter logic [W-1:0] OD_MASK = '0,
    parameter int           EVO_BIT = 5
) (
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] pin_sync,
    input  logic         evo_en,
    input  logic         evo_val,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] rd_port
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        if (OD_MASK[b]) begin : g_od
            assign pin_out[b] = 1'b0;
            assign pin_oe[b]  = dir_q[b] & ~data_q[b];
        end else if (b == EVO_BIT) begin : g_evo
            assign pin_out[b] = evo_en ? evo_val : data_q[b];
            assign pin_oe[b]  = evo_en | dir_q[b];
        end else begin : g_pp
            assign pin_out[b] = data_q[b];
            assign pin_oe[b]  = dir_q[b];
        end
        assign rd_port[b] = dir_q[b] ? data_q[b] : pin_sync[b];
    end
endmodule

// File: rtl/shared_gpio_port.sv
module shared_gpio_port
    import gpio_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int IRQ_BIT_A   = 7,
    parameter int IRQ_BIT_B   = 6,
    parameter int EVO_BIT     = 5,
    parameter int EVI_BIT     = 4,
    parameter int CAP_BIT     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic [IRQ_CH-1:0] pull_up_en,
    input  logic              evo_en,
    input  logic              evo_val,
    output logic              tmr_event_o,
    output logic              tmr_capture_o,
    output logic [IRQ_CH-1:0] irq_req
);
    localparam logic [PORT_W-1:0] OD_MASK =
        PORT_W'((1 << IRQ_BIT_A) | (1 << IRQ_BIT_B));

    reg_sel_e          sel;
    logic [PORT_W-1:0] data_q, dir_q, pin_sync, rd_port;
    logic [IRQ_CH-1:0] pull_q, en_q, flag_q, irq_src, fall;
    logic              wr_data, wr_dir, wr_pull, wr_ctl;

    assign sel     = reg_sel_e'(bus_addr);
    assign wr_data = bus_wr && (sel == REG_DATA);
    assign wr_dir  = bus_wr && (sel == REG_DIR);
    assign wr_pull = bus_wr && (sel == REG_PULL);
    assign wr_ctl  = bus_wr && (sel == REG_CTL);

    gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
    );

    gpio_pad_mux #(.W(PORT_W), .OD_MASK(OD_MASK), .EVO_BIT(EVO_BIT)) u_mux (
        .data_q(data_q), .dir_q(dir_q), .pin_sync(pin_sync),
        .evo_en(evo_en), .evo_val(evo_val),
        .pin_out(pin_out), .pin_oe(pin_oe), .rd_port(rd_port)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            pull_q <= '0;
            en_q   <= '0;
        end else begin
            if (wr_data) data_q <= bus_wdata;
            if (wr_dir)  dir_q  <= bus_wdata;
            if (wr_pull) pull_q <= {bus_wdata[IRQ_BIT_B], bus_wdata[IRQ_BIT_A]};
            if (wr_ctl)  en_q   <= bus_wdata[EN_LSB +: IRQ_CH];
        end
    end

    for (genvar c = 0; c < IRQ_CH; c++) begin : g_chan
        localparam int SRC_BIT = (c == 0) ? IRQ_BIT_A : IRQ_BIT_B;
        assign irq_src[c] = rd_port[SRC_BIT];

        gpio_fall_fsm u_edge (
            .clk(clk), .rst_n(rst_n), .src(irq_src[c]), .fall(fall[c])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                flag_q[c] <= 1'b0;
            else if (fall[c])                          flag_q[c] <= 1'b1;
            else if (wr_ctl && bus_wdata[FLAG_LSB+c])  flag_q[c] <= 1'b0;
        end
    end

    assign irq_req       = flag_q & en_q;
    assign pull_up_en    = pull_q;
    assign tmr_event_o   = pin_sync[EVI_BIT];
    assign tmr_capture_o = pin_sync[CAP_BIT];

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            REG_DATA: bus_rdata = rd_port;
            REG_DIR:  bus_rdata = dir_q;
            REG_PULL: begin
                bus_rdata[IRQ_BIT_A] = pull_q[0];
                bus_rdata[IRQ_BIT_B] = pull_q[1];
            end
            REG_CTL: begin
                bus_rdata[EN_LSB +: IRQ_CH]   = en_q;
                bus_rdata[FLAG_LSB +: IRQ_CH] = flag_q;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic [7:0] data_q,
    input logic [7:0] dir_q,
    input logic [7:0] pin_out,
    input logic [7:0] pin_oe,
    input logic       evo_en,
    input logic       evo_val,
    input logic [1:0] irq_src,
    input logic [1:0] flag_q,
    input logic [1:0] irq_req
);
    // R5
    evo_owns_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evo_en |-> (pin_oe[5] && pin_out[5] == evo_val));

    // R2
    latch_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd0 && dir_q[2]) |-> bus_rdata[2] == data_q[2]);

    // R7
    flag_a_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[0]) |-> ($past(irq_src[0], 2) && !$past(irq_src[0])));

    // R7
    flag_b_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[1]) |-> ($past(irq_src[1], 2) && !$past(irq_src[1])));

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[0] && !(bus_wr && bus_addr == 2'd3 && bus_wdata[4])) |=> flag_q[0]);

    // R9
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req[1] |-> flag_q[1]);

    // R3
    od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q[7] && data_q[7]) |-> !pin_oe[7]);
endmodule

bind shared_gpio_port gpio_port_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .data_q(data_q),
    .dir_q(dir_q), .pin_out(pin_out), .pin_oe(pin_oe), .evo_en(evo_en),
    .evo_val(evo_val), .irq_src(irq_src), .flag_q(flag_q), .irq_req(irq_req)
);

// File: tb/shared_gpio_port_tb_top.sv
module shared_gpio_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe;
    logic [1:0] pull_up_en, irq_req;
    logic       evo_en = 1'b0, evo_val = 1'b0;
    logic       tmr_event_o, tmr_capture_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    shared_gpio_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pull_up_en(pull_up_en),
        .evo_en(evo_en), .evo_val(evo_val), .tmr_event_o(tmr_event_o),
        .tmr_capture_o(tmr_capture_o), .irq_req(irq_req)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd1, v); check("R1 dir", v, 8'h00);
        rd(2'd2, v); check("R1 pull", v, 8'h00);
        rd(2'd3, v); check("R1 ctl", v, 8'h00);
        rd(2'd0, v); check("R1 data", v, 8'h00);
        check("R1 oe", pin_oe, 8'h00);
        check("R1 pull/irq", {4'h0, pull_up_en, irq_req}, 8'h00);
    endtask

    task automatic t_readback();
        logic [7:0] v;
        pin_in = 8'h3C;
        wr(2'd0, 8'hA5);
        wr(2'd1, 8'hF0);
        cycles(3);
        rd(2'd0, v); check("R2 mixed", v, (8'hA5 & 8'hF0) | (8'h3C & 8'h0F));
        wr(2'd1, 8'h0F);
        rd(2'd0, v); check("R2 swapped", v, (8'hA5 & 8'h0F) | (8'h3C & 8'hF0));
    endtask

    task automatic t_sync_latency();
        logic [7:0] v;
        wr(2'd1, 8'h00);
        pin_in = 8'h00;
        cycles(3);
        pin_in = 8'h01;
        cycles(1);
        rd(2'd0, v); check("R10 one edge", v & 8'h01, 8'h00);
        cycles(1);
        rd(2'd0, v); check("R10 two edges", v & 8'h01, 8'h01);
    endtask

    task automatic t_open_drain();
        logic [7:0] v;
        wr(2'd0, 8'h80);
        wr(2'd1, 8'hC0);
        check("R3 oe", pin_oe & 8'hC0, 8'h40);
        check("R3 out", pin_out & 8'hC0, 8'h00);
        wr(2'd2, 8'hFF);
        check("R3 pullup", {6'h0, pull_up_en}, 8'h03);
        rd(2'd2, v); check("R3 pull read", v, 8'hC0);
        wr(2'd2, 8'h7F);
        check("R3 pullup b", {6'h0, pull_up_en}, 8'h02);
    endtask

    task automatic t_push_pull();
        evo_en = 1'b0;
        wr(2'd0, 8'h2A);
        wr(2'd1, 8'h3F);
        check("R4 oe", pin_oe & 8'h3F, 8'h3F);
        check("R4 out", pin_out & 8'h3F, 8'h2A);
        wr(2'd1, 8'h05);
        check("R4 oe partial", pin_oe & 8'h3F, 8'h05);
    endtask

    task automatic t_evo();
        logic [7:0] v;
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        evo_en = 1'b1; evo_val = 1'b1; pin_in = 8'h20;
        #1;
        check("R5 oe", {7'h0, pin_oe[5]}, 8'h01);
        check("R5 out hi", {7'h0, pin_out[5]}, 8'h01);
        cycles(3);
        rd(2'd0, v); check("R2 evo pin read", v & 8'h20, 8'h20);
        wr(2'd1, 8'h20);
        rd(2'd0, v); check("R2 evo latch read", v & 8'h20, 8'h00);
        evo_val = 1'b0;
        #1 check("R5 out lo", {7'h0, pin_out[5]}, 8'h00);
        evo_en = 1'b0;
        wr(2'd1, 8'h00);
    endtask

    task automatic t_timer_inputs();
        logic [7:0] v;
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h18);
        pin_in = 8'h18;
        cycles(3);
        check("R6 both high", {6'h0, tmr_event_o, tmr_capture_o}, 8'h03);
        rd(2'd0, v); check("R6 latch read", v & 8'h18, 8'h00);
        pin_in = 8'h10;
        cycles(3);
        check("R6 capture edge", {6'h0, tmr_event_o, tmr_capture_o}, 8'h02);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_irq_pin_edge();
        logic [7:0] v;
        wr(2'd1, 8'h00);
        pin_in = 8'h80;
        cycles(4);
        wr(2'd3, 8'h30);
        rd(2'd3, v); check("R7 pre", v & 8'h30, 8'h00);
        pin_in = 8'h00;
        cycles(4);
        rd(2'd3, v); check("R7 pin fall", v & 8'h30, 8'h10);
        check("R9 disabled", {6'h0, irq_req}, 8'h00);
        wr(2'd3, 8'h01);
        check("R9 enabled", {6'h0, irq_req}, 8'h01);
        rd(2'd3, v); check("R8 write0 keeps", v & 8'h30, 8'h10);
        wr(2'd3, 8'h11);
        rd(2'd3, v); check("R8 write1 clears", v & 8'h30, 8'h00);
        check("R9 after clear", {6'h0, irq_req}, 8'h00);
        wr(2'd3, 8'h00);
    endtask

    task automatic t_irq_latch_edge();
        logic [7:0] v;
        pin_in = 8'h00;
        wr(2'd0, 8'h40);
        wr(2'd1, 8'h40);
        cycles(2);
        wr(2'd3, 8'h30);
        wr(2'd0, 8'h00);
        cycles(2);
        rd(2'd3, v); check("R7 latch fall", v & 8'h30, 8'h20);
        wr(2'd3, 8'h22);
        rd(2'd3, v); check("R8 clear b", v & 8'h30, 8'h00);
        wr(2'd0, 8'h40);
        cycles(2);
        wr(2'd0, 8'h00);
        wr(2'd3, 8'h22);
        rd(2'd3, v); check("R8 set beats clear", v & 8'h30, 8'h20);
        check("R9 chan b", {6'h0, irq_req}, 8'h02);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        cycles(3);
        t_reset();
        rst_n = 1'b1;
        cycles(1);
        t_readback();
        t_sync_latency();
        t_open_drain();
        t_push_pull();
        t_evo();
        t_timer_inputs();
        t_irq_pin_edge();
        t_irq_latch_edge();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule